// File: doc/BRIEF.md
# IO Address Translation Table Walker

This block turns a device DMA address into a physical page address. It walks a three-level table held in system memory: region, then segment, then page. Each walk begins with a single-cycle start pulse. The walker samples the DMA address together with the function configuration: table origin, aperture bounds, translation enable and function state. It then reads 64-bit entries through a simple request/response memory port. Only one read is in flight at a time, and the response may arrive after any latency of at least one cycle.

A walk ends with a one-cycle done pulse that carries three results: a read/write or no-access permission, a fault flag and the translated page address. The walker rejects a function that is not in service, and a DMA address outside the aperture, before it reads memory at all. These results stay on the outputs until the next accepted start, so the consumer can pick them up at any time.

Top module: `iova_walker`

## Requirements
- R1: After reset, done, perm_rw, fault and rd_req are all 0, and xlat_addr is 0.
- R2: A walk runs only when xlat_en is 1 and fn_state is 3 (enabled) or 4 (blocked). Any other case finishes with perm_rw=0 and fault=0, and issues no memory read.
- R3: A DMA address below ap_base or above ap_limit finishes with perm_rw=0 and fault=0, and issues no memory read. An address equal to either bound is admitted.
- R4: Each entry is read at table base plus index times 8. The region index is DMA address bits [41:31], the segment index is bits [30:20] and the page index is bits [19:12]. The page offset bits [11:0] do not affect the walk.
- R5: The table origin has bits [11:0] cleared before it is used as the region table base.
- R6: An intermediate entry is followed only when its tag bits [3:2] are 2'b11 at the region level or 2'b10 at the segment level, and its address field (the entry with bits [11:0] cleared) is not zero. Otherwise the walk ends with fault=1 and perm_rw=0.
- R7: The translated address is the page entry with bits [11:0] cleared. If page-entry bit 10 (invalid) is set, the result is perm_rw=0. Otherwise it is perm_rw=1.
- R8: At most one memory read is outstanding: rd_req stays low from a request until its rd_valid response.
- R9: done is high for exactly one cycle per walk. perm_rw, fault and xlat_addr hold their values until the next accepted start.
- R10: A start pulse is ignored while a walk is in progress and in the done cycle.
- R11: Any result with perm_rw=0 reports xlat_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| iova | input | 64 | Device DMA address to translate |
| fn_state | input | 3 | Function state: 0 reserved, 1 standby, 2 disabled, 3 enabled, 4 blocked |
| xlat_en | input | 1 | Translation enable |
| tbl_origin | input | 64 | Region table origin; low 12 bits are flags |
| ap_base | input | 64 | Lowest admitted DMA address |
| ap_limit | input | 64 | Highest admitted DMA address |
| rd_req | output | 1 | Memory read request, one cycle |
| rd_addr | output | 64 | Address of the entry being read |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 64 | Read response entry |
| done | output | 1 | Walk finished, one cycle |
| perm_rw | output | 1 | 1 = read/write, 0 = no access |
| fault | output | 1 | Walk stopped on a bad intermediate entry |
| xlat_addr | output | 64 | Translated page address |

## Verification
A new start pulse can arrive in the same cycle as the end of a walk, or while a read response is still pending. The bench provokes both cases. It raises start in the exact cycle where done is high, and again in the cycle just after a walk has been admitted. It judges each case by three observations: the memory model sees no extra read requests, the held result stays equal to the first walk's expected values, and no second done pulse appears.

// File: rtl/iova_walk_pkg.sv
// Package: shared encodings for the IO address table walker.
// Assumes entries are 64 bits and tags sit in entry bits [3:2].
package iova_walk_pkg;

    // Function service states presented on fn_state
    typedef enum logic [2:0] {
        FS_RESERVED = 3'd0,
        FS_STANDBY  = 3'd1,
        FS_DISABLED = 3'd2,
        FS_ENABLED  = 3'd3,
        FS_BLOCKED  = 3'd4
    } fn_state_e;

    // Walker sequence
    typedef enum logic [2:0] {
        W_IDLE    = 3'd0,
        W_REGION  = 3'd1,
        W_SEGMENT = 3'd2,
        W_PAGE    = 3'd3,
        W_DONE    = 3'd4
    } walk_state_e;

    localparam int        TAG_LSB     = 2;
    localparam logic [1:0] TAG_REGION  = 2'b11;
    localparam logic [1:0] TAG_SEGMENT = 2'b10;

endpackage

// File: rtl/iova_idx_split.sv
// Splits the latched index field of a DMA address into region, segment
// and page indices. Assumes the field starts at the page index LSB.
module iova_idx_split #(
    parameter int FIELD_W = 30,
    parameter int RX_OFF  = 19,
    parameter int RX_W    = 11,
    parameter int SX_OFF  = 8,
    parameter int SX_W    = 11,
    parameter int PX_W    = 8
) (
    input  logic [FIELD_W-1:0] field,
    output logic [RX_W-1:0]    rx,
    output logic [SX_W-1:0]    sx,
    output logic [PX_W-1:0]    px
);
    // Pure slicing of the index field
    always_comb begin
        rx = field[RX_OFF +: RX_W];
        sx = field[SX_OFF +: SX_W];
        px = field[0 +: PX_W];
    end
endmodule

// File: rtl/iova_table_entry.sv
// Decodes one intermediate table entry: checks its level tag and extracts
// the next table base. Assumes table bases are aligned to 2**FLAG_W bytes.
module iova_table_entry
    import iova_walk_pkg::*;
#(
    parameter int         ADDR_W = 64,
    parameter int         FLAG_W = 12,
    parameter logic [1:0] TAG    = TAG_REGION
) (
    input  logic [ADDR_W-1:0] entry,
    output logic              link_ok,
    output logic [ADDR_W-1:0] next_base
);
    logic unused_flags;

    // Keep the low flag bits visible as deliberately ignored
    assign unused_flags = ^entry[FLAG_W-1:0];

    // Tag match and non-zero address decide whether the walk continues
    always_comb begin
        next_base = {entry[ADDR_W-1:FLAG_W], {FLAG_W{1'b0}}};
        link_ok   = (entry[TAG_LSB +: 2] == TAG) && (next_base != '0);
    end
endmodule

// File: rtl/iova_page_entry.sv
// Decodes the final page entry into a page address and a permission.
// Assumes the invalid flag sits inside the low flag field.
module iova_page_entry #(
    parameter int ADDR_W    = 64,
    parameter int FLAG_W    = 12,
    parameter int INVAL_BIT = 10
) (
    input  logic [ADDR_W-1:0] entry,
    output logic              rw_ok,
    output logic [ADDR_W-1:0] page_base
);
    logic unused_flags;

    // Other flag bits carry no meaning for this walker
    assign unused_flags = ^entry[FLAG_W-1:0];

    // Mask flags off the address and read the invalid flag
    always_comb begin
        page_base = {entry[ADDR_W-1:FLAG_W], {FLAG_W{1'b0}}};
        rw_ok     = ~entry[INVAL_BIT];
    end
endmodule

// File: rtl/iova_walk_ctrl.sv
// Sequencer of the walker: admits a start, issues one read per level,
// advances on responses and registers the result. Assumes the memory
// answers each request exactly once, no earlier than one cycle after it.
module iova_walk_ctrl
    import iova_walk_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int FLAG_W  = 12,
    parameter int PX_LSB  = 12,
    parameter int FIELD_W = 30,
    parameter int RX_W    = 11,
    parameter int SX_W    = 11,
    parameter int PX_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  iova,
    input  logic [2:0]         fn_state,
    input  logic               xlat_en,
    input  logic [ADDR_W-1:0]  tbl_origin,
    input  logic [ADDR_W-1:0]  ap_base,
    input  logic [ADDR_W-1:0]  ap_limit,
    input  logic               rd_valid,
    input  logic [RX_W-1:0]    rx,
    input  logic [SX_W-1:0]    sx,
    input  logic [PX_W-1:0]    px,
    input  logic [1:0]         link_ok,
    input  logic [ADDR_W-1:0]  next_base [2],
    input  logic               page_rw_ok,
    input  logic [ADDR_W-1:0]  page_base,
    output logic [FIELD_W-1:0] field_q,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               done,
    output logic               perm_rw,
    output logic               fault,
    output logic [ADDR_W-1:0]  xlat_addr
);
    walk_state_e       state_q;
    logic              pend_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] origin_base;
    logic [ADDR_W-1:0] idx_off;
    logic              in_service;
    logic              in_window;
    logic              admit;
    logic              rsp;
    logic              unused_origin;

    // Origin flag bits never reach the address path
    assign unused_origin = ^tbl_origin[FLAG_W-1:0];
    assign origin_base   = {tbl_origin[ADDR_W-1:FLAG_W], {FLAG_W{1'b0}}};

    // Admission: function in service, translation on, address inside aperture
    always_comb begin
        in_service = (fn_state == FS_ENABLED) || (fn_state == FS_BLOCKED);
        in_window  = (iova >= ap_base) && (iova <= ap_limit);
        admit      = xlat_en && in_service && in_window;
    end

    // Byte offset of the entry selected at the current level
    always_comb begin
        unique case (state_q)
            W_REGION:  idx_off = {{(ADDR_W-RX_W-3){1'b0}}, rx, 3'b000};
            W_SEGMENT: idx_off = {{(ADDR_W-SX_W-3){1'b0}}, sx, 3'b000};
            W_PAGE:    idx_off = {{(ADDR_W-PX_W-3){1'b0}}, px, 3'b000};
            default:   idx_off = '0;
        endcase
    end

    // Memory request: one per level, never while a response is pending
    always_comb begin
        rd_req  = ((state_q == W_REGION) || (state_q == W_SEGMENT) ||
                   (state_q == W_PAGE)) && !pend_q;
        rd_addr = base_q + idx_off;
        rsp     = pend_q && rd_valid;
        done    = (state_q == W_DONE);
    end

    // Walk sequencing, outstanding-read tracking and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= W_IDLE;
            pend_q    <= 1'b0;
            base_q    <= '0;
            field_q   <= '0;
            perm_rw   <= 1'b0;
            fault     <= 1'b0;
            xlat_addr <= '0;
        end else begin
            if (rd_req) pend_q <= 1'b1;
            else if (rsp) pend_q <= 1'b0;
            unique case (state_q)
                W_IDLE: begin
                    if (start) begin
                        field_q   <= iova[PX_LSB +: FIELD_W];
                        perm_rw   <= 1'b0;
                        fault     <= 1'b0;
                        xlat_addr <= '0;
                        if (admit) begin
                            base_q  <= origin_base;
                            state_q <= W_REGION;
                        end else begin
                            state_q <= W_DONE;
                        end
                    end
                end
                W_REGION: begin
                    if (rsp) begin
                        if (link_ok[0]) begin
                            base_q  <= next_base[0];
                            state_q <= W_SEGMENT;
                        end else begin
                            fault   <= 1'b1;
                            state_q <= W_DONE;
                        end
                    end
                end
                W_SEGMENT: begin
                    if (rsp) begin
                        if (link_ok[1]) begin
                            base_q  <= next_base[1];
                            state_q <= W_PAGE;
                        end else begin
                            fault   <= 1'b1;
                            state_q <= W_DONE;
                        end
                    end
                end
                W_PAGE: begin
                    if (rsp) begin
                        perm_rw   <= page_rw_ok;
                        xlat_addr <= page_rw_ok ? page_base : '0;
                        state_q   <= W_DONE;
                    end
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/iova_walker.sv
// Top of the three-level IO address translation walker. Wires the index
// splitter, the two intermediate-entry decoders, the page decoder and the
// sequencer. Assumes a memory port with single-cycle requests and a
// response latency of at least one cycle.
module iova_walker
    import iova_walk_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int FLAG_W    = 12,
    parameter int INVAL_BIT = 10,
    parameter int RX_LSB    = 31,
    parameter int RX_W      = 11,
    parameter int SX_LSB    = 20,
    parameter int SX_W      = 11,
    parameter int PX_LSB    = 12,
    parameter int PX_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] iova,
    input  logic [2:0]        fn_state,
    input  logic              xlat_en,
    input  logic [ADDR_W-1:0] tbl_origin,
    input  logic [ADDR_W-1:0] ap_base,
    input  logic [ADDR_W-1:0] ap_limit,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_data,
    output logic              done,
    output logic              perm_rw,
    output logic              fault,
    output logic [ADDR_W-1:0] xlat_addr
);
    localparam int FIELD_W = RX_LSB + RX_W - PX_LSB;
    localparam int RX_OFF  = RX_LSB - PX_LSB;
    localparam int SX_OFF  = SX_LSB - PX_LSB;

    logic [FIELD_W-1:0] field_q;
    logic [RX_W-1:0]    rx;
    logic [SX_W-1:0]    sx;
    logic [PX_W-1:0]    px;
    logic [1:0]         link_ok;
    logic [ADDR_W-1:0]  next_base [2];
    logic               page_rw_ok;
    logic [ADDR_W-1:0]  page_base;

    iova_idx_split #(
        .FIELD_W(FIELD_W), .RX_OFF(RX_OFF), .RX_W(RX_W),
        .SX_OFF(SX_OFF), .SX_W(SX_W), .PX_W(PX_W)
    ) u_split (
        .field(field_q), .rx(rx), .sx(sx), .px(px)
    );

    // One decoder per intermediate level; the level fixes the expected tag
    for (genvar lv = 0; lv < 2; lv++) begin : g_level
        localparam logic [1:0] LV_TAG = (lv == 0) ? TAG_REGION : TAG_SEGMENT;
        iova_table_entry #(
            .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .TAG(LV_TAG)
        ) u_entry (
            .entry(rd_data), .link_ok(link_ok[lv]), .next_base(next_base[lv])
        );
    end

    iova_page_entry #(
        .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .INVAL_BIT(INVAL_BIT)
    ) u_page (
        .entry(rd_data), .rw_ok(page_rw_ok), .page_base(page_base)
    );

    iova_walk_ctrl #(
        .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .PX_LSB(PX_LSB), .FIELD_W(FIELD_W),
        .RX_W(RX_W), .SX_W(SX_W), .PX_W(PX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .iova(iova),
        .fn_state(fn_state), .xlat_en(xlat_en), .tbl_origin(tbl_origin),
        .ap_base(ap_base), .ap_limit(ap_limit), .rd_valid(rd_valid),
        .rx(rx), .sx(sx), .px(px), .link_ok(link_ok), .next_base(next_base),
        .page_rw_ok(page_rw_ok), .page_base(page_base), .field_q(field_q),
        .rd_req(rd_req), .rd_addr(rd_addr), .done(done), .perm_rw(perm_rw),
        .fault(fault), .xlat_addr(xlat_addr)
    );
endmodule

// File: rtl/iova_walker_chk.sv
// Checker for the walker's port-level timing rules, bound to the top.
module iova_walker_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              done,
    input logic              perm_rw,
    input logic              fault,
    input logic [ADDR_W-1:0] xlat_addr
);
    // R8
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R4
    entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[2:0] == 3'b000));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(perm_rw) && $stable(fault) && $stable(xlat_addr)));

    // R6
    fault_noacc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> !perm_rw);

    // R11
    noacc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !perm_rw) |-> (xlat_addr == '0));
endmodule

bind iova_walker iova_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/iova_walker_bench.sv
module iova_walker_bench;
    localparam int AW = 64;
    localparam logic [AW-1:0] ORIGIN = 64'h0000_0000_0001_0FFF; // flags set: R5
    localparam logic [AW-1:0] APB    = 64'h0000_0000_0000_1000;
    localparam logic [AW-1:0] APL    = 64'h0000_0002_0000_0000;
    localparam logic [AW-1:0] IOVA_A = 64'h0000_0000_8020_3123;

    typedef struct packed {
        logic [63:0] iova;
        logic [2:0]  fst;
        logic        en;
        logic [3:0]  lat;
        logic        ex_rw;
        logic        ex_fault;
        logic [63:0] ex_addr;
        logic [3:0]  ex_reads;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{IOVA_A, 3'd3, 1'b1, 4'd1, 1'b1, 1'b0, 64'hABCDE000, 4'd3, 8'd7},  // R7 good page
        '{64'h80204000, 3'd3, 1'b1, 4'd3, 1'b0, 1'b0, 64'h0, 4'd3, 8'd7},  // R7 invalid page
        '{64'h80300000, 3'd3, 1'b1, 4'd2, 1'b0, 1'b1, 64'h0, 4'd2, 8'd6},  // R6 wrong tag, segment
        '{64'h100000000, 3'd3, 1'b1, 4'd1, 1'b0, 1'b1, 64'h0, 4'd1, 8'd6}, // R6 wrong tag, region
        '{64'h180000000, 3'd3, 1'b1, 4'd1, 1'b0, 1'b1, 64'h0, 4'd1, 8'd6}, // R6 zero address
        '{64'h800, 3'd3, 1'b1, 4'd1, 1'b0, 1'b0, 64'h0, 4'd0, 8'd3},        // R3 below base
        '{64'h200000001, 3'd3, 1'b1, 4'd1, 1'b0, 1'b0, 64'h0, 4'd0, 8'd3},  // R3 above limit
        '{64'h200000000, 3'd3, 1'b1, 4'd2, 1'b0, 1'b1, 64'h0, 4'd1, 8'd3},  // R3 limit admitted
        '{64'h1000, 3'd3, 1'b1, 4'd1, 1'b0, 1'b1, 64'h0, 4'd1, 8'd3},       // R3 base admitted
        '{IOVA_A, 3'd2, 1'b1, 4'd1, 1'b0, 1'b0, 64'h0, 4'd0, 8'd2},         // R2 disabled
        '{IOVA_A, 3'd3, 1'b0, 4'd1, 1'b0, 1'b0, 64'h0, 4'd0, 8'd2},         // R2 enable off
        '{IOVA_A, 3'd4, 1'b1, 4'd2, 1'b1, 1'b0, 64'hABCDE000, 4'd3, 8'd2},  // R2 blocked walks
        '{IOVA_A, 3'd0, 1'b1, 4'd1, 1'b0, 1'b0, 64'h0, 4'd0, 8'd2},         // R2 reserved
        '{64'h80203FFF, 3'd3, 1'b1, 4'd5, 1'b1, 1'b0, 64'hABCDE000, 4'd3, 8'd4} // R4 offset ignored
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] iova = '0;
    logic [2:0]    fn_state = 3'd3;
    logic          xlat_en = 1'b1;
    logic          rd_req, rd_valid, done, perm_rw, fault;
    logic [AW-1:0] rd_addr, rd_data, xlat_addr;

    int tests = 0;
    int fails = 0;
    int nreads = 0;
    logic [3:0] lat_sel = 4'd1;

    always #5 clk = ~clk;

    iova_walker u_iova_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .iova(iova),
        .fn_state(fn_state), .xlat_en(xlat_en), .tbl_origin(ORIGIN),
        .ap_base(APB), .ap_limit(APL), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .perm_rw(perm_rw), .fault(fault), .xlat_addr(xlat_addr)
    );

    // Table contents seen by the walker
    function automatic logic [63:0] mem_at(input logic [63:0] a);
        case (a)
            64'h10008: return 64'h2000C;      // region entry -> segment table
            64'h20010: return 64'h30008;      // segment entry -> page table
            64'h30018: return 64'hABCDE001;   // valid page
            64'h30020: return 64'h55555401;   // invalid page (bit 10)
            64'h20018: return 64'h4000C;      // region tag at segment level
            64'h10010: return 64'h50008;      // segment tag at region level
            64'h10018: return 64'h0000C;      // region tag, zero address
            default:   return 64'h0;
        endcase
    endfunction

    // Memory model with selectable latency
    logic          m_busy = 1'b0;
    logic [3:0]    m_cnt = '0;
    logic [AW-1:0] m_addr = '0;
    always @(posedge clk) begin
        rd_valid <= 1'b0;
        if (rd_req && !m_busy) begin
            m_addr <= rd_addr;
            m_cnt  <= lat_sel;
            m_busy <= 1'b1;
            nreads <= nreads + 1;
        end else if (m_busy) begin
            if (m_cnt <= 4'd1) begin
                rd_valid <= 1'b1;
                rd_data  <= mem_at(m_addr);
                m_busy   <= 1'b0;
            end else begin
                m_cnt <= m_cnt - 4'd1;
            end
        end
    end
    initial rd_data = '0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic [63:0] a, input logic [2:0] fs,
                          input logic en, input logic [3:0] lat);
        @(negedge clk);
        iova = a; fn_state = fs; xlat_en = en; lat_sel = lat; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            tests++; fails++;
            $display("FAIL %s timeout: actual no done expected done", req);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "done", 64'(done), 64'd0);
        chk("R1", "perm_rw", 64'(perm_rw), 64'd0);
        chk("R1", "fault", 64'(fault), 64'd0);
        chk("R1", "rd_req", 64'(rd_req), 64'd0);
        chk("R1", "xlat_addr", xlat_addr, 64'd0);
        rst_n = 1'b1;

        // Vector table; every admitted walk also proves the R5 origin masking
        for (int i = 0; i < NV; i++) begin
            int r0;
            string rq;
            rq = $sformatf("R%0d", VECS[i].req);
            r0 = nreads;
            launch(VECS[i].iova, VECS[i].fst, VECS[i].en, VECS[i].lat);
            wait_done(rq);
            chk(rq, "perm_rw", 64'(perm_rw), 64'(VECS[i].ex_rw));
            chk(rq, "fault", 64'(fault), 64'(VECS[i].ex_fault));
            chk(rq, "xlat_addr", xlat_addr, VECS[i].ex_addr);
            chk(rq, "reads", 64'(nreads - r0), 64'(VECS[i].ex_reads));
            @(negedge clk);
            chk("R9", "done one cycle", 64'(done), 64'd0);
        end

        // R10 start while walk in progress is ignored
        begin
            int r0;
            r0 = nreads;
            launch(IOVA_A, 3'd3, 1'b1, 4'd2);
            iova = 64'h100000000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done("R10");
            chk("R10", "busy start perm_rw", 64'(perm_rw), 64'd1);
            chk("R10", "busy start addr", xlat_addr, 64'hABCDE000);
            chk("R10", "busy start reads", 64'(nreads - r0), 64'd3);
            // R10 start in the done cycle is ignored; R9 result held
            r0 = nreads;
            iova = 64'h80300000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 6; k++) begin
                if (done) begin
                    tests++; fails++;
                    $display("FAIL R10 extra done: actual 1 expected 0");
                end
                @(negedge clk);
            end
            chk("R10", "done-cycle start reads", 64'(nreads - r0), 64'd0);
            chk("R9", "held perm_rw", 64'(perm_rw), 64'd1);
            chk("R9", "held fault", 64'(fault), 64'd0);
            chk("R9", "held addr", xlat_addr, 64'hABCDE000);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #2000000;
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule